// File: doc/BRIEF.md
# Signed Booth Multiply-Accumulate Unit

This block is a purely combinational multiply-accumulate slice for an image filter datapath. It takes an 8-bit signed pixel, an 8-bit signed filter coefficient and a 16-bit running sum. It returns the running sum plus the signed product, wrapped to 16 bits in two's complement. Any pipeline registers belong to the block that instantiates it, and it does not saturate.

The multiplier recodes the coefficient into radix-4 digits, each in the range -2 to +2, and forms one sign-extended partial-product row per digit. A digit is made negative by inverting its row and adding a one at the row's lowest weighted position. The rows and the collected negation ones are reduced by a chain of three-input carry-save adders, and a ripple carry-propagate adder produces the product. The product and the running sum then pass through a further carry-save stage whose third input is tied to zero, and a final carry-propagate adder. Every stage is written at bit level. No behavioural multiply is used.

Top module: `signed_booth_mac`

## Requirements
- R1: `mac_out` equals (`acc_in` + signed(`a_px`) × signed(`b_coef`)) mod 2^16 for every input combination.
- R2: The internal product is the 16-bit two's-complement value of signed(`a_px`) × signed(`b_coef`), with both operands read as two's complement (bit 7 is the sign). This includes -128 × -128 = 0x4000 and -128 × 127 = 0xC080.
- R3: When `a_px` or `b_coef` is zero, `mac_out` equals `acc_in` unchanged.
- R4: Overflow wraps without saturation. `acc_in` = 0x7FFF plus product +1 gives 0x8000, and `acc_in` = 0x8000 plus product -1 gives 0x7FFF.
- R5: The final addition propagates carries across all 16 bits. The carry-save sum plus the carry vector shifted left by one equals product + `acc_in`. As examples, 0xFFFF + 1 gives 0x0000 and 0x00FF + 1 gives 0x0100.
- R6: Every radix-4 digit value is handled. Digits come from coefficient bit triples {b[2i+1], b[2i], b[2i-1]}, with b[-1] = 0, decoded as 000/111 → 0, 001/010 → +1, 011 → +2, 100 → -2, 101/110 → -1. Coefficients 0x55, 0xAA, 0x33, 0xCC, 0x7F, 0x80 and 0xFF give the correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_px | input | 8 | Signed pixel operand |
| b_coef | input | 8 | Signed coefficient operand, recoded into Booth digits |
| acc_in | input | 16 | Running sum to which the product is added |
| mac_out | output | 16 | Wrapped sum of `acc_in` and the product |

## Verification
The unit has no registers, so each result is due in the same cycle its operands are presented. The bench applies new operands one time unit after a rising clock edge. It compares `mac_out` with its behavioural model at the following falling edge, half a period later, once the combinational paths have settled. Each clock therefore carries exactly one stimulus and one comparison. All 65,536 pixel and coefficient pairs are covered, with the running sum rotated through 0, 0x7FFF, 0x8000, 0xFFFF and 0x1234. Targeted cycles follow for the wrap, carry-chain and digit cases.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

    // One radix-4 digit: magnitude select (one or two) and a sign flag
    typedef struct packed {
        logic one;
        logic two;
        logic neg;
    } booth_digit_t;

    // Decode a 3-bit overlapping coefficient window into a digit
    function automatic booth_digit_t booth_decode(input logic [2:0] g);
        booth_digit_t d;
        d.one = g[0] ^ g[1];
        d.two = (g == 3'b011) | (g == 3'b100);
        d.neg = g[2] & ~(g[1] & g[0]);
        return d;
    endfunction

endpackage

// File: rtl/bmac_csa.sv
// Three-input carry-save adder; the carry vector leaves already shifted by one
module bmac_csa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry_sh
);
    logic [W-2:0] maj;

    always_comb begin
        sum      = x ^ y ^ z;
        maj      = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]);
        carry_sh = {maj, 1'b0};
    end
endmodule

// File: rtl/bmac_cpa.sv
// Ripple carry-propagate adder, carry out discarded (modulo 2^W)
module bmac_cpa #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W-1:0] c;

    assign c[0] = 1'b0;

    for (genvar j = 0; j < W; j++) begin : g_bit
        assign s[j] = a[j] ^ b[j] ^ c[j];
        if (j < W - 1) begin : g_carry
            assign c[j+1] = (a[j] & b[j]) | (a[j] & c[j]) | (b[j] & c[j]);
        end
    end
endmodule

// File: rtl/bmac_ppgen.sv
// One partial-product row: select +/-1x or +/-2x of the sign-extended pixel
module bmac_ppgen
    import booth_mac_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int W     = 16,
    parameter int ROW   = 0
) (
    input  logic [PIX_W-1:0] pix,
    input  booth_digit_t     dig,
    output logic [W-1:0]     row
);
    localparam int SHIFT = 2 * ROW;

    logic [W-1:0] ext1, ext2, mult, inv;

    always_comb begin
        ext1 = {{(W - PIX_W){pix[PIX_W-1]}}, pix};
        ext2 = {ext1[W-2:0], 1'b0};
        mult = ({W{dig.one}} & ext1) | ({W{dig.two}} & ext2);
        inv  = mult ^ {W{dig.neg}};
        row  = inv << SHIFT;
    end
endmodule

// File: rtl/bmac_booth_mul.sv
// Radix-4 Booth multiplier: recode, build rows, carry-save chain, ripple add
module bmac_booth_mul
    import booth_mac_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8
) (
    input  logic [PIX_W-1:0]        pix,
    input  logic [COEF_W-1:0]       coef,
    output logic [PIX_W+COEF_W-1:0] prod
);
    localparam int W    = PIX_W + COEF_W;
    localparam int NDIG = COEF_W / 2;
    localparam int NCSA = NDIG - 1;

    logic [COEF_W:0]       coef_ext;
    booth_digit_t [NDIG-1:0] digits;
    logic [W-1:0]          rows [NDIG];
    logic [W-1:0]          corr;
    logic [W-1:0]          st_s [NCSA];
    logic [W-1:0]          st_c [NCSA];

    assign coef_ext = {coef, 1'b0};

    for (genvar i = 0; i < NDIG; i++) begin : g_digit
        assign digits[i] = booth_decode(coef_ext[2*i+2 -: 3]);

        bmac_ppgen #(.PIX_W(PIX_W), .W(W), .ROW(i)) u_pp (
            .pix (pix),
            .dig (digits[i]),
            .row (rows[i])
        );
    end

    // Two's-complement "+1" for every negated row, at that row's weight
    always_comb begin
        corr = '0;
        for (int i = 0; i < NDIG; i++) begin
            corr[2*i] = digits[i].neg;
        end
    end

    for (genvar k = 0; k < NCSA; k++) begin : g_red
        logic [W-1:0] in_x, in_y, in_z;
        if (k == 0) begin : g_first
            assign in_x = rows[0];
            assign in_y = rows[1];
        end else begin : g_next
            assign in_x = st_s[k-1];
            assign in_y = st_c[k-1];
        end
        if (k + 2 < NDIG) begin : g_row
            assign in_z = rows[k+2];
        end else begin : g_corr
            assign in_z = corr;
        end

        bmac_csa #(.W(W)) u_csa (
            .x        (in_x),
            .y        (in_y),
            .z        (in_z),
            .sum      (st_s[k]),
            .carry_sh (st_c[k])
        );
    end

    bmac_cpa #(.W(W)) u_cpa (
        .a (st_s[NCSA-1]),
        .b (st_c[NCSA-1]),
        .s (prod)
    );
endmodule

// File: rtl/signed_booth_mac.sv
// Top: Booth product, then carry-save merge with the running sum, then ripple add
module signed_booth_mac #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8,
    localparam int ACC_W = PIX_W + COEF_W
) (
    input  logic [PIX_W-1:0]  a_px,
    input  logic [COEF_W-1:0] b_coef,
    input  logic [ACC_W-1:0]  acc_in,
    output logic [ACC_W-1:0]  mac_out
);
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] csa_sum;
    logic [ACC_W-1:0] csa_cs;

    bmac_booth_mul #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_mul (
        .pix  (a_px),
        .coef (b_coef),
        .prod (prod)
    );

    bmac_csa #(.W(ACC_W)) u_acc_csa (
        .x        (prod),
        .y        (acc_in),
        .z        ('0),
        .sum      (csa_sum),
        .carry_sh (csa_cs)
    );

    bmac_cpa #(.W(ACC_W)) u_acc_cpa (
        .a (csa_sum),
        .b (csa_cs),
        .s (mac_out)
    );
endmodule

// File: rtl/signed_booth_mac_chk.sv
// Checker relating the stages of the unit; attached below with bind
module signed_booth_mac_chk #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 16
) (
    input logic [PIX_W-1:0]  a_px,
    input logic [COEF_W-1:0] b_coef,
    input logic [ACC_W-1:0]  acc_in,
    input logic [ACC_W-1:0]  prod,
    input logic [ACC_W-1:0]  csa_sum,
    input logic [ACC_W-1:0]  csa_cs,
    input logic [ACC_W-1:0]  mac_out
);
    logic [ACC_W-1:0] sa, sb, exp_prod, merged, target;

    always_comb begin
        sa       = {{(ACC_W - PIX_W){a_px[PIX_W-1]}}, a_px};
        sb       = {{(ACC_W - COEF_W){b_coef[COEF_W-1]}}, b_coef};
        exp_prod = sa * sb;
        merged   = csa_sum + csa_cs;
        target   = prod + acc_in;

        // R2: multiplier stage yields the signed product
        assert_product_R2: assert (prod == exp_prod)
            else $error("product mismatch");
        // R5: carry-save pair carries the full sum of product and running sum
        assert_csa_merge_R5: assert (merged == target)
            else $error("carry-save merge mismatch");
        // R5: final adder resolves the carry-save pair
        assert_cpa_R5: assert (mac_out == merged)
            else $error("carry-propagate mismatch");
        // R1: overall result
        assert_mac_result_R1: assert (mac_out == acc_in + exp_prod)
            else $error("mac result mismatch");
        // R3: zero operand leaves the running sum alone
        assert_zero_pass_R3: assert (!(a_px == '0 || b_coef == '0) || mac_out == acc_in)
            else $error("zero operand altered sum");
    end
endmodule

bind signed_booth_mac signed_booth_mac_chk #(
    .PIX_W (PIX_W),
    .COEF_W(COEF_W),
    .ACC_W (ACC_W)
) u_chk (
    .a_px    (a_px),
    .b_coef  (b_coef),
    .acc_in  (acc_in),
    .prod    (prod),
    .csa_sum (csa_sum),
    .csa_cs  (csa_cs),
    .mac_out (mac_out)
);

// File: tb/signed_booth_mac_test.sv
module signed_booth_mac_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  a_px = '0;
    logic [7:0]  b_coef = '0;
    logic [15:0] acc_in = '0;
    logic [15:0] mac_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    signed_booth_mac uut (
        .a_px    (a_px),
        .b_coef  (b_coef),
        .acc_in  (acc_in),
        .mac_out (mac_out)
    );

    function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] b,
                                          input logic [15:0] acc);
        int pa, pb, r;
        pa = int'($signed(a));
        pb = int'($signed(b));
        r  = pa * pb + int'(acc);
        return r[15:0];
    endfunction

    task automatic compare(input string req, input logic [15:0] exp);
        checks++;
        if (mac_out !== exp) begin
            fails++;
            $display("FAIL %s: a=%h b=%h acc=%h got %h expected %h",
                     req, a_px, b_coef, acc_in, mac_out, exp);
        end
    endtask

    // Drive just after a rising edge, compare at the next falling edge
    task automatic apply(input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] acc, input string req);
        @(posedge clk);
        #1;
        a_px   = a;
        b_coef = b;
        acc_in = acc;
        @(negedge clk);
        compare(req, model(a, b, acc));
    endtask

    task automatic apply_exp(input logic [7:0] a, input logic [7:0] b,
                             input logic [15:0] acc, input logic [15:0] exp,
                             input string req);
        @(posedge clk);
        #1;
        a_px   = a;
        b_coef = b;
        acc_in = acc;
        @(negedge clk);
        compare(req, exp);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
    end

    // Watchdog
    initial begin
        wait (cycles > 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] accs [5];
        accs[0] = 16'h0000;
        accs[1] = 16'h7FFF;
        accs[2] = 16'h8000;
        accs[3] = 16'hFFFF;
        accs[4] = 16'h1234;

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // Reset state: all inputs zero gives zero (R3)
        compare("R3 reset", 16'h0000);

        // R2 extremes with explicit expected values
        apply_exp(8'h80, 8'h80, 16'h0000, 16'h4000, "R2");
        apply_exp(8'h80, 8'h7F, 16'h0000, 16'hC080, "R2");
        apply_exp(8'h7F, 8'h7F, 16'h0000, 16'h3F01, "R2");
        apply_exp(8'hFF, 8'hFF, 16'h0000, 16'h0001, "R2");

        // R3 zero operands
        apply_exp(8'h00, 8'h80, 16'hBEEF, 16'hBEEF, "R3");
        apply_exp(8'h93, 8'h00, 16'h7FFF, 16'h7FFF, "R3");

        // R4 wrap without saturation
        apply_exp(8'h01, 8'h01, 16'h7FFF, 16'h8000, "R4");
        apply_exp(8'hFF, 8'h01, 16'h8000, 16'h7FFF, "R4");
        apply_exp(8'h80, 8'h80, 16'h7FFF, 16'hBFFF, "R4");

        // R5 full carry propagation
        apply_exp(8'h01, 8'h01, 16'hFFFF, 16'h0000, "R5");
        apply_exp(8'h01, 8'h01, 16'h00FF, 16'h0100, "R5");
        apply_exp(8'hFF, 8'hFF, 16'h7FFF, 16'h8000, "R5");

        // R6 every digit pattern, several pixels
        begin
            logic [7:0] coefs [7];
            logic [7:0] pixs [4];
            coefs[0] = 8'h55; coefs[1] = 8'hAA; coefs[2] = 8'h33;
            coefs[3] = 8'hCC; coefs[4] = 8'h7F; coefs[5] = 8'h80;
            coefs[6] = 8'hFF;
            pixs[0] = 8'h80; pixs[1] = 8'h7F; pixs[2] = 8'hA5; pixs[3] = 8'h03;
            for (int ci = 0; ci < 7; ci++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    apply(pixs[pi], coefs[ci], 16'h1234, "R6");
                end
            end
        end

        // R1 exhaustive pairs, running sum rotated through boundary values
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] iv;
            iv = 16'(i);
            apply(iv[7:0], iv[15:8], accs[i % 5], "R1");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule